// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address after a translation-cache miss. It does this by reading two 32-bit translation entries from memory, one after the other. The address splits into three fields. From the top down they are a 10-bit directory index, a 10-bit table index and a 12-bit page offset. The first read uses the directory index and the base register to fetch a directory entry. That entry names the physical frame that holds the page table. The second read uses the table index to fetch the leaf entry, which holds the physical frame of the page.

In every entry, bit 0 is the present flag and bits 31:12 carry a 20-bit frame number. All other entry bits are ignored. If a directory entry is absent, the walk ends at once and no second read is made. The block reports each walk as either a successful translation or a page fault, and the report lasts one cycle. A successful translation gives the frame number for refilling the cache and the full physical address. A fault gives the virtual address that failed. The block handles one walk at a time and uses a simple word-read port to memory, whose reply may arrive after any number of cycles.

Top module: `xlat_walker`

## Requirements
- R1: After reset the walker is idle: `ready` is 1 and `mem_rd_req`, `done` and `fault` are all 0.
- R2: A request is taken only when `req_valid` is high while `ready` is high. `req_valid` seen during a walk is ignored: it starts no walk and produces no result.
- R3: The first read of a walk goes to `dir_base + 4 * vaddr[31:22]`.
- R4: If the directory entry has bit 0 clear, the walk ends with a fault after that single read. No table read is made, and `fault_vaddr` equals the request address.
- R5: If the directory entry has bit 0 set, the second read goes to `{dir_entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R6: If the table entry has bit 0 clear, the walk ends with a fault and `fault_vaddr` equals the request address.
- R7: If the table entry has bit 0 set, the walk ends with `done_pfn = table_entry[31:12]` and `done_paddr = {table_entry[31:12], vaddr[11:0]}`. Entry bits 11:1 have no effect at either level.
- R8: A read is a one-cycle `mem_rd_req` pulse. Data is accepted on a later cycle with `mem_rd_valid` high, and any latency is allowed. While a read waits, `mem_rd_addr` holds steady and no other request is issued.
- R9: `done` and `fault` are never high together. Each is high for exactly one cycle per walk, and `ready` is high in the cycle that follows.
- R10: `dir_base` is sampled when a request is taken. Changing it during a walk does not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| dir_base | input | 32 | Physical byte address of the directory |
| ready | output | 1 | Walker idle; a request is taken this cycle |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Read byte address, held until data returns |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read entry |
| done | output | 1 | One-cycle successful translation pulse |
| done_paddr | output | 32 | Physical address, valid with `done` |
| done_pfn | output | 20 | Frame number for refill, valid with `done` |
| fault | output | 1 | One-cycle page-fault pulse |
| fault_vaddr | output | 32 | Faulting virtual address, valid with `fault` |

## Verification
Walks are run against a memory model filled with hand-placed entries, so that every ending can be told apart. The cases are: a full hit, a directory miss with an empty entry, a directory miss where only bit 0 is clear, and a leaf miss. Extreme indices (all zeros and all ones) check the address arithmetic at both ends. Read latencies from zero to six extra cycles show that the data is taken only at the valid strobe. A change of base register in the middle of a walk shows when the base is sampled, and repeated requests sent while busy show that they are dropped. A closing run mixes random offsets and table indices under random latency.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_RD_DIR = 3'd1,
      ST_WT_DIR = 3'd2,
      ST_RD_TBL = 3'd3,
      ST_WT_TBL = 3'd4,
      ST_FINISH = 3'd5
   } walk_st_e;

endpackage

// File: rtl/xlat_addr_gen.sv
`timescale 1ns/1ps
module xlat_addr_gen #(
   parameter int PA_W        = 32,
   parameter int IDX_W       = 10,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [PA_W-1:0]  base,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  addr
);
   localparam int SH   = $clog2(ENTRY_BYTES);
   localparam bit POW2 = ((1 << SH) == ENTRY_BYTES);

   if (IDX_W + SH >= PA_W) begin : g_bad_width
      $error("xlat_addr_gen: index span exceeds address width");
   end

   if (POW2) begin : g_shift
      logic [PA_W-1:0] off;
      assign off  = PA_W'(idx) << SH;
      assign addr = base + off;
   end else begin : g_mul
      assign addr = base + PA_W'(idx) * PA_W'(ENTRY_BYTES);
   end
endmodule

// File: rtl/xlat_entry_decode.sv
`timescale 1ns/1ps
module xlat_entry_decode #(
   parameter int ENTRY_W     = 32,
   parameter int FRAME_W     = 20,
   parameter int PRESENT_BIT = 0
) (
   input  logic [ENTRY_W-1:0] entry,
   output logic               present,
   output logic [FRAME_W-1:0] frame
);
   if (FRAME_W >= ENTRY_W) begin : g_bad_frame
      $error("xlat_entry_decode: frame field does not fit the entry");
   end
   if (PRESENT_BIT >= ENTRY_W - FRAME_W) begin : g_bad_flag
      $error("xlat_entry_decode: present flag overlaps the frame field");
   end

   logic unused_low;

   assign frame      = entry[ENTRY_W-1 -: FRAME_W];
   assign present    = entry[PRESENT_BIT];
   assign unused_low = ^entry[ENTRY_W-FRAME_W-1:0];
endmodule

// File: rtl/xlat_ctrl.sv
`timescale 1ns/1ps
module xlat_ctrl
   import xlat_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid,
   input  logic     mem_rd_valid,
   input  logic     ent_present,
   output walk_st_e st,
   output logic     accept,
   output logic     dir_hit,
   output logic     tbl_hit
);
   walk_st_e st_nx;

   assign accept  = (st == ST_IDLE) && req_valid;
   assign dir_hit = (st == ST_WT_DIR) && mem_rd_valid;
   assign tbl_hit = (st == ST_WT_TBL) && mem_rd_valid;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:   if (accept) st_nx = ST_RD_DIR;
         ST_RD_DIR: st_nx = ST_WT_DIR;
         ST_WT_DIR: if (dir_hit) st_nx = ent_present ? ST_RD_TBL : ST_FINISH;
         ST_RD_TBL: st_nx = ST_WT_TBL;
         ST_WT_TBL: if (tbl_hit) st_nx = ST_FINISH;
         ST_FINISH: st_nx = ST_IDLE;
         default:   st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end
endmodule

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int DIR_W       = 10,
   parameter int TBL_W       = 10,
   parameter int OFF_W       = 12,
   parameter int ENTRY_W     = 32,
   parameter int PRESENT_BIT = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [VA_W-1:0]       req_vaddr,
   input  logic [PA_W-1:0]       dir_base,
   output logic                  ready,
   output logic                  mem_rd_req,
   output logic [PA_W-1:0]       mem_rd_addr,
   input  logic                  mem_rd_valid,
   input  logic [ENTRY_W-1:0]    mem_rd_data,
   output logic                  done,
   output logic [PA_W-1:0]       done_paddr,
   output logic [PA_W-OFF_W-1:0] done_pfn,
   output logic                  fault,
   output logic [VA_W-1:0]       fault_vaddr
);
   localparam int FRAME_W     = PA_W - OFF_W;
   localparam int ENTRY_BYTES = ENTRY_W / 8;

   if (DIR_W + TBL_W + OFF_W != VA_W) begin : g_bad_split
      $error("xlat_walker: index and offset fields must cover the virtual address");
   end
   if (ENTRY_W % 8 != 0) begin : g_bad_entry
      $error("xlat_walker: entry width must be whole bytes");
   end

   walk_st_e st;
   logic accept, dir_hit, tbl_hit;
   logic ent_present;
   logic [FRAME_W-1:0] ent_frame;

   logic [VA_W-1:0]    va_q;
   logic [PA_W-1:0]    base_q;
   logic [FRAME_W-1:0] tframe_q;
   logic [FRAME_W-1:0] rframe_q;
   logic               rfault_q;

   logic [DIR_W-1:0] dir_idx;
   logic [TBL_W-1:0] tbl_idx;
   logic [PA_W-1:0]  tbl_base;
   logic [PA_W-1:0]  dir_addr;
   logic [PA_W-1:0]  tbl_addr;

   xlat_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .mem_rd_valid (mem_rd_valid),
      .ent_present  (ent_present),
      .st           (st),
      .accept       (accept),
      .dir_hit      (dir_hit),
      .tbl_hit      (tbl_hit)
   );

   xlat_entry_decode #(
      .ENTRY_W     (ENTRY_W),
      .FRAME_W     (FRAME_W),
      .PRESENT_BIT (PRESENT_BIT)
   ) u_dec (
      .entry   (mem_rd_data),
      .present (ent_present),
      .frame   (ent_frame)
   );

   assign dir_idx  = va_q[VA_W-1 -: DIR_W];
   assign tbl_idx  = va_q[OFF_W+TBL_W-1 -: TBL_W];
   assign tbl_base = {tframe_q, {OFF_W{1'b0}}};

   xlat_addr_gen #(
      .PA_W        (PA_W),
      .IDX_W       (DIR_W),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_dir_addr (
      .base (base_q),
      .idx  (dir_idx),
      .addr (dir_addr)
   );

   xlat_addr_gen #(
      .PA_W        (PA_W),
      .IDX_W       (TBL_W),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_tbl_addr (
      .base (tbl_base),
      .idx  (tbl_idx),
      .addr (tbl_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_q     <= '0;
         base_q   <= '0;
         tframe_q <= '0;
         rframe_q <= '0;
         rfault_q <= 1'b0;
      end else begin
         if (accept) begin
            va_q     <= req_vaddr;
            base_q   <= dir_base;
            rfault_q <= 1'b0;
         end
         if (dir_hit) begin
            tframe_q <= ent_frame;
            if (!ent_present) rfault_q <= 1'b1;
         end
         if (tbl_hit) begin
            rframe_q <= ent_frame;
            rfault_q <= !ent_present;
         end
      end
   end

   assign ready       = (st == ST_IDLE);
   assign mem_rd_req  = (st == ST_RD_DIR) || (st == ST_RD_TBL);
   assign mem_rd_addr = ((st == ST_RD_TBL) || (st == ST_WT_TBL)) ? tbl_addr : dir_addr;
   assign done        = (st == ST_FINISH) && !rfault_q;
   assign fault       = (st == ST_FINISH) && rfault_q;
   assign done_paddr  = {rframe_q, va_q[OFF_W-1:0]};
   assign done_pfn    = rframe_q;
   assign fault_vaddr = va_q;
endmodule

// File: rtl/xlat_walker_chk.sv
`timescale 1ns/1ps
module xlat_walker_chk #(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int DIR_W       = 10,
   parameter int OFF_W       = 12,
   parameter int ENTRY_BYTES = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ready,
   input logic            req_valid,
   input logic [VA_W-1:0] req_vaddr,
   input logic [PA_W-1:0] dir_base,
   input logic            mem_rd_req,
   input logic [PA_W-1:0] mem_rd_addr,
   input logic            mem_rd_valid,
   input logic            done,
   input logic [PA_W-1:0] done_paddr,
   input logic            fault,
   input logic [VA_W-1:0] fault_vaddr
);
   logic [VA_W-1:0] cap_va;
   logic [PA_W-1:0] cap_base;
   logic [1:0]      rd_cnt;
   logic            outstanding;
   logic [PA_W-1:0] first_addr;

   assign first_addr = cap_base + PA_W'(cap_va[VA_W-1 -: DIR_W]) * PA_W'(ENTRY_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_va      <= '0;
         cap_base    <= '0;
         rd_cnt      <= '0;
         outstanding <= 1'b0;
      end else begin
         if (ready && req_valid) begin
            cap_va   <= req_vaddr;
            cap_base <= dir_base;
            rd_cnt   <= '0;
         end else if (mem_rd_req && rd_cnt != 2'd3) begin
            rd_cnt <= rd_cnt + 2'd1;
         end
         if (mem_rd_req)        outstanding <= 1'b1;
         else if (mem_rd_valid) outstanding <= 1'b0;
      end
   end

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!mem_rd_req && !done && !fault));

   assert_first_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && rd_cnt == 2'd0) |-> (mem_rd_addr == first_addr));

   assert_fault_va_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (fault_vaddr == cap_va));

   assert_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_paddr[OFF_W-1:0] == cap_va[OFF_W-1:0]));

   assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd_req || outstanding) && !mem_rd_valid) |=> $stable(mem_rd_addr));

   assert_single_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding |-> !mem_rd_req);

   assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   assert_done_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_fault_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);
endmodule

bind xlat_walker xlat_walker_chk #(
   .VA_W        (VA_W),
   .PA_W        (PA_W),
   .DIR_W       (DIR_W),
   .OFF_W       (OFF_W),
   .ENTRY_BYTES (ENTRY_W / 8)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ready        (ready),
   .req_valid    (req_valid),
   .req_vaddr    (req_vaddr),
   .dir_base     (dir_base),
   .mem_rd_req   (mem_rd_req),
   .mem_rd_addr  (mem_rd_addr),
   .mem_rd_valid (mem_rd_valid),
   .done         (done),
   .done_paddr   (done_paddr),
   .fault        (fault),
   .fault_vaddr  (fault_vaddr)
);

// File: tb/sim_xlat_walker.sv
`timescale 1ns/1ps
module sim_xlat_walker;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [31:0] req_vaddr;
   logic [31:0] dir_base;
   logic        ready;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_data;
   logic        done;
   logic [31:0] done_paddr;
   logic [19:0] done_pfn;
   logic        fault;
   logic [31:0] fault_vaddr;

   always #2 clk = ~clk;

   xlat_walker u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_vaddr    (req_vaddr),
      .dir_base     (dir_base),
      .ready        (ready),
      .mem_rd_req   (mem_rd_req),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_data  (mem_rd_data),
      .done         (done),
      .done_paddr   (done_paddr),
      .done_pfn     (done_pfn),
      .fault        (fault),
      .fault_vaddr  (fault_vaddr)
   );

   typedef struct {
      bit          is_fault;
      logic [31:0] val;
      logic [19:0] pfn;
      string       tag;
   } res_t;

   int   checks = 0;
   int   fails  = 0;
   bit   ended  = 1'b0;
   int   lat_cfg = 0;
   bit   lat_rand = 1'b0;
   logic [31:0] pmem [logic [31:0]];
   logic [31:0] exp_addr_q [$];
   string       exp_tag_q  [$];
   res_t        exp_res_q  [$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rdm(input logic [31:0] a);
      return pmem.exists(a) ? pmem[a] : 32'h0;
   endfunction

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // driver: computes the expected reads and result, then issues the request
   task automatic walk(input logic [31:0] va, input string tag,
                       input bit junk, input bit swap_base);
      logic [31:0] da, de, ta, te;
      res_t r;
      da = dir_base + {20'h0, va[31:22], 2'b00};
      de = rdm(da);
      exp_addr_q.push_back(da);
      exp_tag_q.push_back({tag, "/R3"});
      r.tag = tag;
      if (!de[0]) begin
         r.is_fault = 1'b1; r.val = va; r.pfn = '0;
         r.tag = {tag, "/R4"};
      end else begin
         ta = {de[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
         te = rdm(ta);
         exp_addr_q.push_back(ta);
         exp_tag_q.push_back({tag, "/R5"});
         if (!te[0]) begin
            r.is_fault = 1'b1; r.val = va; r.pfn = '0;
            r.tag = {tag, "/R6"};
         end else begin
            r.is_fault = 1'b0; r.val = {te[31:12], va[11:0]}; r.pfn = te[31:12];
            r.tag = {tag, "/R7"};
         end
      end
      exp_res_q.push_back(r);
      @(negedge clk);
      while (!ready) @(negedge clk);
      req_vaddr = va;
      req_valid = 1'b1;
      @(negedge clk);
      if (swap_base) dir_base = ~dir_base;
      if (junk) begin
         req_vaddr = ~va;
         for (int k = 0; k < 3; k++) @(negedge clk);
      end
      req_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_res_q.size() != 0 || !ready) @(negedge clk);
      @(negedge clk);
   endtask

   // memory responder
   initial begin
      logic [31:0] a;
      int lat;
      bit pending;
      mem_rd_valid = 1'b0;
      mem_rd_data  = 32'hDEAD_BEEF;
      forever begin
         @(negedge clk);
         pending = mem_rd_req;
         while (pending) begin
            a = mem_rd_addr;
            if (exp_addr_q.size() == 0) begin
               chk(1'b0, "R4", "unexpected read", a, 32'h0);
            end else begin
               logic [31:0] ea;
               string et;
               ea = exp_addr_q.pop_front();
               et = exp_tag_q.pop_front();
               chk(a == ea, et, "read address", a, ea);
            end
            lat = lat_rand ? int'($urandom_range(0, 6)) : lat_cfg;
            for (int k = 0; k <= lat; k++) begin
               @(negedge clk);
               chk(mem_rd_addr == a, "R8", "address held", mem_rd_addr, a);
               chk(!mem_rd_req, "R8", "no second request", {31'h0, mem_rd_req}, 32'h0);
            end
            mem_rd_valid = 1'b1;
            mem_rd_data  = rdm(a);
            @(negedge clk);
            mem_rd_valid = 1'b0;
            mem_rd_data  = 32'hDEAD_BEEF;
            pending = mem_rd_req;
         end
      end
   end

   // monitor: compares results against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && (done || fault)) begin
            chk(!(done && fault), "R9", "done and fault together", {30'h0, done, fault}, 32'h0);
            if (exp_res_q.size() == 0) begin
               chk(1'b0, "R2", "unexpected result", fault ? fault_vaddr : done_paddr, 32'h0);
            end else begin
               res_t e;
               e = exp_res_q.pop_front();
               chk(fault == e.is_fault, e.tag, "result kind", {31'h0, fault}, {31'h0, e.is_fault});
               if (e.is_fault) begin
                  chk(fault_vaddr == e.val, e.tag, "fault address", fault_vaddr, e.val);
               end else begin
                  chk(done_paddr == e.val, e.tag, "physical address", done_paddr, e.val);
                  chk(done_pfn == e.pfn, e.tag, "frame number", {12'h0, done_pfn}, {12'h0, e.pfn});
               end
            end
            @(negedge clk);
            chk(!done && !fault, "R9", "pulse longer than one cycle", {30'h0, done, fault}, 32'h0);
            chk(ready, "R9", "ready after result", {31'h0, ready}, 32'h1);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
         summary();
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_vaddr = '0;
      dir_base  = 32'h0010_0000;

      pmem[32'h0010_0004] = 32'h0020_0FFF;  // dir 0x001, present, junk low bits
      pmem[32'h0020_000C] = 32'h0ABC_D0F1;  // tbl 0x003, present, junk low bits
      pmem[32'h0010_0008] = 32'h0030_0FFE;  // dir 0x002, absent
      pmem[32'h0010_0FFC] = 32'h0040_0001;  // dir 0x3FF
      pmem[32'h0040_0FFC] = 32'hFFFF_F001;  // tbl 0x3FF
      pmem[32'h0040_0014] = 32'h1234_5000;  // tbl 0x005, absent
      pmem[32'h0010_0000] = 32'h0050_0001;  // dir 0x000
      pmem[32'h0050_0000] = 32'h0000_1003;  // tbl 0x000
      pmem[32'h0080_0004] = 32'h0060_0001;  // alternate directory, dir 0x001
      pmem[32'h0060_000C] = 32'h0777_7001;  // alternate table 0x003

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after reset
      chk(ready, "R1", "ready after reset", {31'h0, ready}, 32'h1);
      chk(!mem_rd_req, "R1", "read request after reset", {31'h0, mem_rd_req}, 32'h0);
      chk(!done && !fault, "R1", "result after reset", {30'h0, done, fault}, 32'h0);

      walk(32'h0040_3ABC, "R7", 1'b0, 1'b0);
      walk(32'h0080_1234, "R4", 1'b0, 1'b0);
      walk(32'h0C00_0000, "R4", 1'b0, 1'b0);
      walk(32'hFFFF_FFFF, "R7", 1'b0, 1'b0);
      walk(32'hFFC0_5000, "R6", 1'b0, 1'b0);
      walk(32'h0000_0000, "R7", 1'b0, 1'b0);
      drain();

      for (int l = 0; l < 7; l++) begin
         lat_cfg = l;
         walk(32'h0040_3000 + 32'(l), "R8", 1'b0, 1'b0);
         walk(32'h0080_0000 + 32'(l), "R8", 1'b0, 1'b0);
      end
      drain();
      lat_cfg = 1;

      dir_base = 32'h0080_0000;
      walk(32'h0040_3ABC, "R3", 1'b0, 1'b0);
      drain();
      dir_base = 32'h0010_0000;
      walk(32'h0040_3ABC, "R10", 1'b0, 1'b1);
      drain();
      dir_base = 32'h0010_0000;

      walk(32'h0040_3111, "R2", 1'b1, 1'b0);
      walk(32'h0080_2222, "R2", 1'b1, 1'b0);
      drain();

      lat_rand = 1'b1;
      for (int i = 0; i < 24; i++) begin
         logic [31:0] va;
         va = $urandom;
         case (i % 4)
            0: va[31:22] = 10'h001;
            1: va[31:22] = 10'h3FF;
            2: va[31:22] = 10'h000;
            default: ;
         endcase
         if (i % 8 == 1) va[21:12] = 10'h3FF;
         if (i % 8 == 4) va[21:12] = 10'h003;
         walk(va, "R7", 1'b0, 1'b0);
      end
      drain();

      chk(exp_addr_q.size() == 0, "R5", "reads left unissued", 32'(exp_addr_q.size()), 32'h0);
      chk(exp_res_q.size() == 0, "R9", "results left unreported", 32'(exp_res_q.size()), 32'h0);

      ended = 1'b1;
      summary();
      $finish;
   end
endmodule